// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte stream. Software builds a circular ring of descriptors in memory. Each descriptor names a buffer and its length. Software hands descriptors to the engine by moving a producer index forward. The engine keeps its own consumer index. While the two differ and the engine is enabled, it fetches the descriptor at the consumer position and streams the buffer bytes out through a ready/valid byte port. It then marks the descriptor as done in memory and advances the consumer index, wrapping it at the programmed ring length.

Registers are reached through a single-cycle write strobe with a combinational read port. Memory is reached through a word-wide port. That port holds a request until it is granted and then waits for a read response, with at most one access in flight. A port number carried in each descriptor is presented beside the frame bytes as sideband.

Top module: `txring_dma`

## Requirements
- R1: After reset the consumer index reads 0, the busy flag reads 0, and tx_valid and mem_req are low.
- R2: A descriptor is four 32-bit words starting at ring base + index*16. The engine reads word 0 (buffer byte address), word 1 (bit 31 done, bit 30 last-segment, bits 29:16 length) and word 3 (bits 26:24 port). It works only while config bit 0 is set and the consumer index differs from the producer index.
- R3: The buffer bytes leave in increasing address order for any start alignment. The byte at address b is lane b[1:0] of its word, with lane 0 in bits 7:0.
- R4: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_last and tx_port hold.
- R5: tx_last is high only on the final byte of a descriptor whose last-segment bit is set. tx_port equals word 3 bits 26:24 for every byte of that descriptor.
- R6: After the final byte, the engine writes word 1 back with bit 31 set and its other bits as fetched, but only when config bit 6 is set. With bit 6 clear, memory is not written.
- R7: A length of zero sends no bytes, and the descriptor is still written back and consumed.
- R8: After each descriptor the consumer index becomes index+1, or 0 when index+1 reaches the ring count (offset 0x04).
- R9: Config bit 1 reads 1 while a descriptor is in flight and 0 otherwise. Clearing bit 0 lets the current descriptor finish and then starts no further descriptor.
- R10: Writing a value with bit 0 set to offset 0x14 forces the consumer index to 0. That offset reads 0.
- R11: A memory request keeps its address, direction and data stable until granted, and no new request is raised while a read response is pending.
- R12: Register offsets are: ring base 0x00, ring count 0x04, producer index 0x08, consumer index 0x0C (read-only; writes ignored) and config 0x10. All read back what was written, in the bits that exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Byte accepted when high with tx_valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_port | output | PORT_W | Destination port sideband |

## Verification
The bench builds the engine with a 4-bit index, 32-bit addresses, 14-bit lengths and little-endian lanes. It programs a ring count of four, so a short run wraps the consumer index back to zero. The 4-bit index keeps the index arithmetic narrow and still covers the modulo step. The bench toggles the memory grant and the byte-port ready, which exercises request holding and output stalls at unaligned buffer starts. It also covers zero-length descriptors, write-back turned off, disabling while a descriptor is in flight, and the index reset.

// File: rtl/txring_pkg.sv
package txring_pkg;
   localparam int REG_AW = 5;
   localparam logic [REG_AW-1:0] OFS_BASE = 5'h00;
   localparam logic [REG_AW-1:0] OFS_CNT  = 5'h04;
   localparam logic [REG_AW-1:0] OFS_PROD = 5'h08;
   localparam logic [REG_AW-1:0] OFS_CONS = 5'h0C;
   localparam logic [REG_AW-1:0] OFS_CFG  = 5'h10;
   localparam logic [REG_AW-1:0] OFS_IRST = 5'h14;

   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_BUSY_BIT = 1;
   localparam int CFG_WB_BIT   = 6;

   localparam int D_DONE_BIT = 31;
   localparam int D_LS_BIT   = 30;
   localparam int D_LEN_LSB  = 16;
   localparam int D_PORT_LSB = 24;
   localparam int DESC_SHIFT = 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DRD, ST_DWAIT, ST_BRD, ST_BWAIT, ST_EMIT, ST_WB, ST_ADV
   } st_e;
endpackage

// File: rtl/txring_regs.sv
module txring_regs
   import txring_pkg::*;
#(
   parameter int AW    = 32,
   parameter int IDX_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [REG_AW-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic                 busy,
   input  logic                 adv,
   output logic [AW-1:0]        base,
   output logic [IDX_W-1:0]     prod_idx,
   output logic [IDX_W-1:0]     cons_idx,
   output logic                 en,
   output logic                 wb_en
);
   localparam int CNT_W = IDX_W + 1;

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] inc;
   logic [IDX_W-1:0] nxt;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;
   assign inc = {1'b0, cons_idx} + CNT_W'(1);
   assign nxt = (inc >= count) ? '0 : inc[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base     <= '0;
         count    <= '0;
         prod_idx <= '0;
         en       <= 1'b0;
         wb_en    <= 1'b0;
      end else if (wr) begin
         case (addr)
            OFS_BASE: base     <= wdata[AW-1:0];
            OFS_CNT:  count    <= wdata[CNT_W-1:0];
            OFS_PROD: prod_idx <= wdata[IDX_W-1:0];
            OFS_CFG: begin
               en    <= wdata[CFG_EN_BIT];
               wb_en <= wdata[CFG_WB_BIT];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cons_idx <= '0;
      else if (wr && addr == OFS_IRST && wdata[0])
         cons_idx <= '0;
      else if (adv)
         cons_idx <= nxt;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_BASE: rdata[AW-1:0]    = base;
         OFS_CNT:  rdata[CNT_W-1:0] = count;
         OFS_PROD: rdata[IDX_W-1:0] = prod_idx;
         OFS_CONS: rdata[IDX_W-1:0] = cons_idx;
         OFS_CFG: begin
            rdata[CFG_EN_BIT]   = en;
            rdata[CFG_BUSY_BIT] = busy;
            rdata[CFG_WB_BIT]   = wb_en;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/txring_lane.sv
module txring_lane #(
   parameter bit BIG_LANES = 1'b0
) (
   input  logic [31:0] word,
   input  logic [1:0]  sel,
   output logic [7:0]  byte_o
);
   generate
      if (BIG_LANES) begin : g_big
         assign byte_o = word[{~sel, 3'b000} +: 8];
      end else begin : g_little
         assign byte_o = word[{sel, 3'b000} +: 8];
      end
   endgenerate
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
   import txring_pkg::*;
#(
   parameter int AW     = 32,
   parameter int IDX_W  = 8,
   parameter int LEN_W  = 14,
   parameter int PORT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wb_en,
   input  logic [AW-1:0]     base,
   input  logic [IDX_W-1:0]  prod_idx,
   input  logic [IDX_W-1:0]  cons_idx,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              tx_last,
   output logic [PORT_W-1:0] tx_port,
   output logic [31:0]       word_q,
   output logic [1:0]        lane_sel,
   output logic              busy,
   output logic              adv
);
   st_e               st;
   logic [1:0]        dsel;
   logic [AW-1:0]     desc_a;
   logic [AW-1:0]     buf_a;
   logic [31:0]       w1_q;
   logic [LEN_W-1:0]  rem;
   logic              ls_q;
   logic [PORT_W-1:0] port_q;
   logic [AW-1:0]     idx_ofs;
   logic [AW-1:0]     d_ofs;
   st_e               fin_st;

   assign idx_ofs = AW'({cons_idx, {DESC_SHIFT{1'b0}}});
   assign d_ofs   = (dsel == 2'd2) ? AW'(12) : AW'({dsel, 2'b00});
   assign fin_st  = wb_en ? ST_WB : ST_ADV;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         dsel   <= '0;
         desc_a <= '0;
         buf_a  <= '0;
         w1_q   <= '0;
         rem    <= '0;
         ls_q   <= 1'b0;
         port_q <= '0;
         word_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (en && (prod_idx != cons_idx)) begin
               st     <= ST_DRD;
               dsel   <= '0;
               desc_a <= base + idx_ofs;
            end
            ST_DRD: if (mem_gnt) st <= ST_DWAIT;
            ST_DWAIT: if (mem_rvalid) begin
               case (dsel)
                  2'd0: buf_a <= mem_rdata[AW-1:0];
                  2'd1: begin
                     w1_q <= mem_rdata;
                     rem  <= mem_rdata[D_LEN_LSB +: LEN_W];
                     ls_q <= mem_rdata[D_LS_BIT];
                  end
                  default: port_q <= mem_rdata[D_PORT_LSB +: PORT_W];
               endcase
               if (dsel == 2'd2)
                  st <= (rem == '0) ? fin_st : ST_BRD;
               else begin
                  dsel <= dsel + 2'd1;
                  st   <= ST_DRD;
               end
            end
            ST_BRD: if (mem_gnt) st <= ST_BWAIT;
            ST_BWAIT: if (mem_rvalid) begin
               word_q <= mem_rdata;
               st     <= ST_EMIT;
            end
            ST_EMIT: if (tx_ready) begin
               buf_a <= buf_a + AW'(1);
               rem   <= rem - LEN_W'(1);
               if (rem == LEN_W'(1))
                  st <= fin_st;
               else if (buf_a[1:0] == 2'b11)
                  st <= ST_BRD;
            end
            ST_WB: if (mem_gnt) st <= ST_ADV;
            ST_ADV: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_BRD:  mem_addr = {buf_a[AW-1:2], 2'b00};
         ST_WB:   mem_addr = desc_a + AW'(4);
         default: mem_addr = desc_a + d_ofs;
      endcase
   end

   assign mem_req   = (st == ST_DRD) || (st == ST_BRD) || (st == ST_WB);
   assign mem_we    = (st == ST_WB);
   assign mem_wdata = w1_q | (32'h1 << D_DONE_BIT);
   assign tx_valid  = (st == ST_EMIT);
   assign tx_last   = (st == ST_EMIT) && (rem == LEN_W'(1)) && ls_q;
   assign tx_port   = port_q;
   assign lane_sel  = buf_a[1:0];
   assign busy      = (st != ST_IDLE);
   assign adv       = (st == ST_ADV);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
   import txring_pkg::*;
#(
   parameter int AW        = 32,
   parameter int IDX_W     = 8,
   parameter int LEN_W     = 14,
   parameter int PORT_W    = 3,
   parameter bit BIG_LANES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [4:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic [PORT_W-1:0] tx_port
);
   generate
      if (AW < IDX_W + DESC_SHIFT || AW > 32) begin : g_bad_aw
         $error("txring_dma: AW must cover the ring and fit 32 bits");
      end
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("txring_dma: IDX_W out of range");
      end
      if (LEN_W < 1 || LEN_W > 14) begin : g_bad_len
         $error("txring_dma: LEN_W must fit the 14-bit length field");
      end
      if (PORT_W < 1 || PORT_W > 3) begin : g_bad_port
         $error("txring_dma: PORT_W must fit the 3-bit port field");
      end
   endgenerate

   logic [AW-1:0]    base_w;
   logic [IDX_W-1:0] prod_w;
   logic [IDX_W-1:0] cons_w;
   logic             en_w;
   logic             wb_en_w;
   logic             busy_w;
   logic             adv_w;
   logic [31:0]      word_w;
   logic [1:0]       sel_w;

   txring_regs #(.AW(AW), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_w), .adv(adv_w),
      .base(base_w), .prod_idx(prod_w), .cons_idx(cons_w),
      .en(en_w), .wb_en(wb_en_w)
   );

   txring_ctrl #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W), .PORT_W(PORT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en_w), .wb_en(wb_en_w), .base(base_w),
      .prod_idx(prod_w), .cons_idx(cons_w),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_last(tx_last), .tx_port(tx_port), .word_q(word_w),
      .lane_sel(sel_w), .busy(busy_w), .adv(adv_w)
   );

   txring_lane #(.BIG_LANES(BIG_LANES)) u_lane (
      .word(word_w), .sel(sel_w), .byte_o(tx_data)
   );
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
   parameter int AW     = 32,
   parameter int IDX_W  = 8,
   parameter int PORT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [AW-1:0]     mem_addr,
   input logic [31:0]       mem_wdata,
   input logic              mem_gnt,
   input logic              mem_rvalid,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [7:0]        tx_data,
   input logic              tx_last,
   input logic [PORT_W-1:0] tx_port,
   input logic              busy,
   input logic              wb_en,
   input logic [IDX_W-1:0]  cons_idx
);
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_port));

   assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   assert_wb_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_wdata[31] && wb_en);

   assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cons_idx) |-> (cons_idx == '0) || (cons_idx == $past(cons_idx) + IDX_W'(1)));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_valid && !mem_req);

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   assert_one_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> !mem_req);
endmodule

bind txring_dma txring_dma_chk #(.AW(AW), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
   .mem_rvalid(mem_rvalid), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_data(tx_data), .tx_last(tx_last), .tx_port(tx_port),
   .busy(busy_w), .wb_en(wb_en_w), .cons_idx(cons_w)
);

// File: tb/txring_dma_test.sv
module txring_dma_test;
   localparam int AW = 32;
   localparam int IDX_W = 4;
   localparam int PORT_W = 3;
   localparam logic [31:0] RING = 32'h40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic mem_gnt = 1'b1;
   logic mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic tx_valid;
   logic tx_ready = 1'b1;
   logic [7:0] tx_data;
   logic tx_last;
   logic [PORT_W-1:0] tx_port;

   logic [31:0] mem [0:255];
   logic hw_en = 1'b0;
   logic [31:0] hw_addr = '0;
   logic [31:0] hw_data = '0;
   logic bp_on = 1'b0;
   logic gnt_slow = 1'b0;
   int cyc = 0;
   logic [11:0] exp_q [$];
   int tb_total = 0, tb_fail = 0, mon_total = 0, mon_fail = 0;

   always #5 clk = ~clk;

   txring_dma #(.AW(AW), .IDX_W(IDX_W), .LEN_W(14), .PORT_W(PORT_W)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .tx_port(tx_port)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      tx_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
      mem_gnt  = gnt_slow ? (cyc % 2 == 0) : 1'b1;
   end

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (hw_en) mem[hw_addr[9:2]] <= hw_data;
      if (mem_req && mem_gnt) begin
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         else begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[9:2]];
         end
      end
   end

   // scoreboard monitor (R3, R5)
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         mon_total++;
         if (exp_q.size() == 0) begin
            mon_fail++;
            $display("FAIL R3 unexpected byte actual=%h expected=none", tx_data);
         end else begin
            logic [11:0] e;
            e = exp_q.pop_front();
            if ({tx_port, tx_last, tx_data} !== e) begin
               mon_fail++;
               $display("FAIL R3 R5 byte actual=%h expected=%h", {tx_port, tx_last, tx_data}, e);
            end
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tb_total++;
      if (act !== exp) begin
         tb_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic host_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      hw_addr = a; hw_data = d; hw_en = 1'b1;
      @(posedge clk); #1;
      hw_en = 1'b0;
   endtask

   function automatic logic [7:0] pat(input logic [31:0] a, input logic [7:0] seed);
      return a[7:0] ^ seed;
   endfunction

   task automatic push_exp(input logic [31:0] a, input int len, input logic ls,
                           input logic [2:0] port, input logic [7:0] seed);
      for (int i = 0; i < len; i++)
         exp_q.push_back({port, ls && (i == len - 1), pat(a + i, seed)});
   endtask

   task automatic post(input int idx, input logic [31:0] a, input int len, input logic ls,
                       input logic [2:0] port, input logic [7:0] seed, input logic push);
      logic [31:0] d;
      if (len > 0) begin
         for (logic [31:0] wa = {a[31:2], 2'b00}; wa <= ((a + len - 1) & ~32'h3); wa += 4)
            host_write(wa, {pat(wa + 3, seed), pat(wa + 2, seed), pat(wa + 1, seed), pat(wa, seed)});
      end
      d = RING + idx * 16;
      host_write(d, a);
      host_write(d + 4, {1'b0, ls, 14'(len), 16'h0055});
      host_write(d + 8, 32'h0);
      host_write(d + 12, {5'b0, port, 24'h0});
      if (push) push_exp(a, len, ls, port, seed);
   endtask

   task automatic wait_cons(input int idx);
      logic [31:0] c, g;
      for (int i = 0; i < 3000; i++) begin
         reg_read(5'h0C, c);
         reg_read(5'h10, g);
         if (c == idx && g[1] == 1'b0) break;
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic run_tests;
      logic [31:0] v;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      reg_read(5'h0C, v); chk("R1 cons idx", v, 0);
      reg_read(5'h10, v); chk("R1 busy", {31'b0, v[1]}, 0);
      chk("R1 tx_valid", {31'b0, tx_valid}, 0);
      chk("R1 mem_req", {31'b0, mem_req}, 0);
      // R12 register map
      reg_write(5'h00, RING);
      reg_write(5'h04, 4);
      reg_write(5'h10, 32'h41);
      reg_read(5'h00, v); chk("R12 base", v, RING);
      reg_read(5'h04, v); chk("R12 count", v, 4);
      reg_read(5'h10, v); chk("R12 cfg", v, 32'h41);
      // R2 R3 R5 R6 aligned frame, last set
      post(0, 32'h100, 5, 1'b1, 3'd3, 8'h5A, 1'b1);
      reg_write(5'h08, 1);
      wait_cons(1);
      chk("R3 all bytes seen", exp_q.size(), 0);
      chk("R6 done written", mem[(RING >> 2) + 1], {1'b1, 1'b1, 14'd5, 16'h0055});
      reg_read(5'h0C, v); chk("R8 step", v, 1);
      // R3 R4 R5 unaligned, no last, stalls
      bp_on = 1'b1; gnt_slow = 1'b1;
      post(1, 32'h103, 9, 1'b0, 3'd5, 8'hC3, 1'b1);
      reg_write(5'h08, 2);
      wait_cons(2);
      chk("R3 R4 unaligned bytes", exp_q.size(), 0);
      chk("R11 R6 done after stalls", mem[(RING >> 2) + 5], {1'b1, 1'b0, 14'd9, 16'h0055});
      // R7 zero length
      post(2, 32'h140, 0, 1'b1, 3'd1, 8'h00, 1'b1);
      reg_write(5'h08, 3);
      wait_cons(3);
      chk("R7 done on empty", mem[(RING >> 2) + 9], {1'b1, 1'b1, 14'd0, 16'h0055});
      chk("R7 no bytes", exp_q.size(), 0);
      // R6 write-back off, R8 wrap
      reg_write(5'h10, 32'h01);
      post(3, 32'h140, 4, 1'b1, 3'd7, 8'h11, 1'b1);
      reg_write(5'h08, 0);
      wait_cons(0);
      chk("R6 no write-back", mem[(RING >> 2) + 13], {1'b0, 1'b1, 14'd4, 16'h0055});
      reg_read(5'h0C, v); chk("R8 wrap", v, 0);
      // R9 disable while in flight
      reg_write(5'h10, 32'h41);
      post(0, 32'h180, 40, 1'b1, 3'd2, 8'h77, 1'b1);
      post(1, 32'h1C0, 6, 1'b1, 3'd4, 8'h99, 1'b0);
      reg_write(5'h08, 2);
      repeat (5) @(posedge clk);
      reg_read(5'h10, v); chk("R9 busy in flight", {31'b0, v[1]}, 1);
      reg_write(5'h10, 32'h40);
      wait_cons(1);
      repeat (60) @(posedge clk);
      reg_read(5'h0C, v); chk("R9 stopped after current", v, 1);
      reg_read(5'h10, v); chk("R9 busy low", {31'b0, v[1]}, 0);
      chk("R9 first finished", exp_q.size(), 0);
      push_exp(32'h1C0, 6, 1'b1, 3'd4, 8'h99);
      reg_write(5'h10, 32'h41);
      wait_cons(2);
      chk("R9 resumed", exp_q.size(), 0);
      // R12 consumer index read-only
      reg_write(5'h0C, 3);
      reg_read(5'h0C, v); chk("R12 cons read-only", v, 2);
      // R10 index reset
      reg_write(5'h10, 32'h0);
      reg_write(5'h14, 1);
      reg_read(5'h0C, v); chk("R10 cons cleared", v, 0);
      reg_read(5'h14, v); chk("R10 reads zero", v, 0);
      reg_read(5'h08, v); chk("R12 prod kept", v, 2);
      repeat (20) @(posedge clk);
      chk("R10 no bytes while off", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            tb_total++; tb_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", (tb_total + mon_total) - (tb_fail + mon_fail), tb_total + mon_total);
      $finish;
   end
endmodule